// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This controller runs the refill of one cache line after a miss. It accepts a miss request made of a line address and the offset of the word the processor is waiting for. It then reads every word of the line from a slower memory, one word per read request. Each returned word is written straight into the line buffer through a write port. When the word the processor asked for comes back, the controller raises a one-cycle data-valid pulse, so the processor can resume before the rest of the line has arrived.

A mode input, sampled when the miss is accepted, sets the fetch order. In wrap mode the reads start at the missed word and continue upward modulo the line length. In linear mode the reads start at word zero and go upward, and the missed word is forwarded when it arrives in that order. The memory port takes a valid/ready request and returns responses in request order after a fixed latency. The controller does not need to know that latency, because it counts returned beats.

The controller holds a busy output high for the whole refill. It keeps its line-valid output low until the last word is written, so any access that depends on the line waits until then. It accepts a new miss only when idle.

Top module: `cwf_refill_ctrl`

## Requirements
- R1: `miss_ready` is high exactly when `busy` is low. A miss is accepted in a cycle with `miss_valid` and `miss_ready` high. `busy` is high from the cycle after acceptance until the cycle after the final word is written. Requests presented while busy are ignored.
- R2: Each refill issues exactly 8 read requests. The address of each is `{line, word_index}`, with the word index in the low 3 bits. A request is held with a stable address until `mem_req_ready` is seen high.
- R3: With `order_mode` = 0 (wrap), the word indices are requested in the order k, k+1, ..., 7, 0, ..., k-1, where k is the accepted offset.
- R4: With `order_mode` = 1 (linear), the word indices are requested in the order 0, 1, ..., 7, whatever the value of k.
- R5: Every memory response during a refill drives `fill_we` high in that same cycle. `fill_idx` is the index of the matching request, taken in issue order, and `fill_data` is the returned word.
- R6: `cpu_valid` pulses for exactly one cycle per refill, in the cycle the word at offset k is returned. In that cycle `cpu_data` equals the returned word.
- R7: `line_valid` is low after reset and from the cycle after acceptance. It rises in the cycle after the eighth word is written and stays high until the next miss is accepted.
- R8: Memory responses that arrive while the controller is idle cause no `fill_we` and no `cpu_valid`.
- R9: Changes to `order_mode`, `miss_line` or `miss_word` after acceptance do not alter the running refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Controller idle, request accepted |
| miss_line | input | LINE_W | Line address of the miss |
| miss_word | input | 3 | Offset of the requested word |
| order_mode | input | 1 | 0 = wrap from requested word, 1 = linear from word zero |
| mem_req_valid | output | 1 | Word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | LINE_W+3 | Word address {line, index} |
| mem_rsp_valid | input | 1 | Returned word present |
| mem_rsp_data | input | DATA_W | Returned word |
| fill_we | output | 1 | Line buffer write enable |
| fill_idx | output | 3 | Line buffer word index |
| fill_data | output | DATA_W | Line buffer write data |
| cpu_valid | output | 1 | Requested word available (one-cycle pulse) |
| cpu_data | output | DATA_W | Requested word |
| line_valid | output | 1 | Whole line present |
| busy | output | 1 | Refill in progress |

## Verification
The assertions check, on every cycle, several properties of the protocol. They check that a stalled request keeps its address. They check that the first request after acceptance carries the missed offset in wrap mode and zero in linear mode. They check that the processor pulse never lasts two cycles, that line-valid and busy are never high together, and that busy falls only right after a buffer write. Only the bench's scenarios can show the rest. That covers the complete wrapped and linear index sequences for every offset, and the pairing of each returned word with its buffer index. It also covers the single forwarded word per refill, refills issued back to back, ignored stray responses, and mode changes in the middle of a refill.

// File: rtl/cwf_refill_ctrl.sv
module cwf_refill_ctrl #(
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  parameter int LINE_W = 27
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        miss_valid,
  output logic                        miss_ready,
  input  logic [LINE_W-1:0]           miss_line,
  input  logic [$clog2(WORDS)-1:0]    miss_word,
  input  logic                        order_mode,
  output logic                        mem_req_valid,
  input  logic                        mem_req_ready,
  output logic [LINE_W+$clog2(WORDS)-1:0] mem_req_addr,
  input  logic                        mem_rsp_valid,
  input  logic [DATA_W-1:0]           mem_rsp_data,
  output logic                        fill_we,
  output logic [$clog2(WORDS)-1:0]    fill_idx,
  output logic [DATA_W-1:0]           fill_data,
  output logic                        cpu_valid,
  output logic [DATA_W-1:0]           cpu_data,
  output logic                        line_valid,
  output logic                        busy
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int CNT_W = OFF_W + 1;
  localparam logic [CNT_W-1:0] ALL  = CNT_W'(WORDS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

  logic              busy_q, lv_q, linear_q;
  logic [LINE_W-1:0] line_q;
  logic [OFF_W-1:0]  off_q, base;
  logic [CNT_W-1:0]  iss_q, rsp_q;
  logic              accept, issue, last;

  assign base       = linear_q ? '0 : off_q;
  assign miss_ready = !busy_q;
  assign accept     = miss_valid && miss_ready;

  assign mem_req_valid = busy_q && (iss_q != ALL);
  assign mem_req_addr  = {line_q, base + iss_q[OFF_W-1:0]};
  assign issue         = mem_req_valid && mem_req_ready;

  assign fill_we   = busy_q && mem_rsp_valid;
  assign fill_idx  = base + rsp_q[OFF_W-1:0];
  assign fill_data = mem_rsp_data;
  assign cpu_valid = fill_we && (fill_idx == off_q);
  assign cpu_data  = mem_rsp_data;
  assign last      = fill_we && (rsp_q == LAST);

  assign busy       = busy_q;
  assign line_valid = lv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      lv_q     <= 1'b0;
      linear_q <= 1'b0;
      line_q   <= '0;
      off_q    <= '0;
      iss_q    <= '0;
      rsp_q    <= '0;
    end else if (accept) begin
      busy_q   <= 1'b1;
      lv_q     <= 1'b0;
      linear_q <= order_mode;
      line_q   <= miss_line;
      off_q    <= miss_word;
      iss_q    <= '0;
      rsp_q    <= '0;
    end else begin
      if (issue)   iss_q <= iss_q + 1'b1;
      if (fill_we) rsp_q <= rsp_q + 1'b1;
      if (last) begin
        busy_q <= 1'b0;
        lv_q   <= 1'b1;
      end
    end
  end

  p_accept_starts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> (busy && !line_valid && !miss_ready));

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_wrap_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready && !order_mode) |=>
      (mem_req_valid && mem_req_addr[OFF_W-1:0] == $past(miss_word)));

  p_linear_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready && order_mode) |=>
      (mem_req_valid && mem_req_addr[OFF_W-1:0] == '0));

  p_done_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(fill_we) && line_valid));

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid |=> !cpu_valid);

  p_lv_excl_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> !busy);
endmodule

// File: tb/cwf_refill_ctrl_tb.sv
module cwf_refill_ctrl_tb;
  localparam int WORDS = 8, DATA_W = 32, LINE_W = 27, OFF_W = 3, LAT = 3;
  localparam int AW = LINE_W + OFF_W;

  logic clk = 0, rst_n = 0;
  logic miss_valid = 0, order_mode = 0, mem_req_ready = 0, mem_rsp_valid = 0;
  logic [LINE_W-1:0] miss_line = '0;
  logic [OFF_W-1:0] miss_word = '0;
  logic [DATA_W-1:0] mem_rsp_data = '0;
  logic miss_ready, mem_req_valid, fill_we, cpu_valid, line_valid, busy;
  logic [AW-1:0] mem_req_addr;
  logic [OFF_W-1:0] fill_idx;
  logic [DATA_W-1:0] fill_data, cpu_data;

  always #4 clk = ~clk;

  cwf_refill_ctrl #(.WORDS(WORDS), .DATA_W(DATA_W), .LINE_W(LINE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_line(miss_line), .miss_word(miss_word), .order_mode(order_mode),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .fill_we(fill_we), .fill_idx(fill_idx), .fill_data(fill_data),
    .cpu_valid(cpu_valid), .cpu_data(cpu_data), .line_valid(line_valid), .busy(busy));

  int checks = 0, errors = 0, cyc = 0;
  bit m_busy = 0, m_lv = 0;
  int m_k = 0, m_got = 0, cpu_seen = 0;
  logic [AW-1:0] exp_req[$];
  logic [AW-1:0] pend_addr[$];
  int pend_due[$];
  bit from_pend = 0, stall_en = 0, stray_en = 0, want_miss = 0;
  logic [LINE_W-1:0] w_line;
  int w_word = 0, w_mode = 0;
  logic [AW-1:0] rsp_addr;

  function automatic logic [DATA_W-1:0] word_of(logic [AW-1:0] a);
    return 32'h5A00_0000 ^ (DATA_W'(a) * 32'd2654435761);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic set_inputs();
    miss_valid = want_miss;
    if (m_busy) begin
      miss_line = LINE_W'(cyc * 13);
      miss_word = OFF_W'(cyc);
      order_mode = cyc[0];
    end else begin
      miss_line = w_line;
      miss_word = OFF_W'(w_word);
      order_mode = w_mode[0];
    end
    mem_req_ready = stall_en ? (cyc % 3 != 1) : 1'b1;
    from_pend = 0;
    mem_rsp_valid = 0;
    mem_rsp_data = '0;
    if (pend_due.size() > 0 && pend_due[0] == cyc) begin
      from_pend = 1;
      rsp_addr = pend_addr[0];
      mem_rsp_valid = 1;
      mem_rsp_data = word_of(rsp_addr);
    end else if (stray_en && !m_busy) begin
      mem_rsp_valid = 1;
      mem_rsp_data = 32'hDEAD_0000 | DATA_W'(cyc);
    end
  endtask

  task automatic compare();
    bit exp_fw, exp_cv;
    chk(miss_ready === !m_busy, "R1", "miss_ready", 64'(miss_ready), 64'(!m_busy));
    chk(busy === m_busy, "R1", "busy", 64'(busy), 64'(m_busy));
    chk(line_valid === m_lv, "R7", "line_valid", 64'(line_valid), 64'(m_lv));
    chk(mem_req_valid === (m_busy && exp_req.size() > 0), "R2", "mem_req_valid",
        64'(mem_req_valid), 64'(m_busy && exp_req.size() > 0));
    if (m_busy && exp_req.size() > 0)
      chk(mem_req_addr === exp_req[0], "R2 R3 R4 R9", "mem_req_addr", 64'(mem_req_addr), 64'(exp_req[0]));
    exp_fw = m_busy && from_pend;
    exp_cv = exp_fw && (int'(rsp_addr[OFF_W-1:0]) == m_k);
    chk(fill_we === exp_fw, exp_fw ? "R5" : "R8", "fill_we", 64'(fill_we), 64'(exp_fw));
    chk(cpu_valid === exp_cv, exp_fw ? "R6" : "R8", "cpu_valid", 64'(cpu_valid), 64'(exp_cv));
    if (exp_fw) begin
      chk(fill_idx === rsp_addr[OFF_W-1:0], "R5", "fill_idx", 64'(fill_idx), 64'(rsp_addr[OFF_W-1:0]));
      chk(fill_data === word_of(rsp_addr), "R5", "fill_data", 64'(fill_data), 64'(word_of(rsp_addr)));
    end
    if (exp_cv)
      chk(cpu_data === word_of(rsp_addr), "R6", "cpu_data", 64'(cpu_data), 64'(word_of(rsp_addr)));
  endtask

  task automatic update();
    if (want_miss && !m_busy) begin
      m_busy = 1; m_lv = 0; m_k = w_word; m_got = 0; cpu_seen = 0;
      exp_req.delete();
      for (int n = 0; n < WORDS; n++) begin
        int ix;
        ix = (w_mode == 0) ? (w_word + n) % WORDS : n;
        exp_req.push_back({w_line, OFF_W'(ix)});
      end
    end else if (m_busy) begin
      if (mem_req_ready && exp_req.size() > 0) begin
        pend_addr.push_back(exp_req.pop_front());
        pend_due.push_back(cyc + LAT);
      end
      if (from_pend) begin
        if (int'(rsp_addr[OFF_W-1:0]) == m_k) cpu_seen++;
        void'(pend_addr.pop_front());
        void'(pend_due.pop_front());
        m_got++;
        if (m_got == WORDS) begin
          m_busy = 0; m_lv = 1;
          chk(cpu_seen == 1, "R6", "forwards per refill", 64'(cpu_seen), 64'd1);
        end
      end
    end
  endtask

  task automatic step();
    set_inputs();
    @(negedge clk);
    compare();
    @(posedge clk);
    #1;
    update();
    cyc++;
  endtask

  task automatic run_refill(logic [LINE_W-1:0] line, int k, int mode, bit stall);
    w_line = line; w_word = k; w_mode = mode; stall_en = stall; stray_en = 0;
    want_miss = 1;
    step();
    while (m_busy) step();
    want_miss = 0;
  endtask

  initial begin
    #160000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(busy === 0 && miss_ready === 1, "R1", "idle after reset", 64'({busy, miss_ready}), 64'b01);
    chk(line_valid === 0, "R7", "line_valid after reset", 64'(line_valid), 64'd0);
    @(posedge clk); #1;
    // R8: stray responses while idle
    stray_en = 1;
    repeat (3) step();
    stray_en = 0;
    for (int mode = 0; mode < 2; mode++)
      for (int k = 0; k < WORDS; k++) begin
        run_refill(LINE_W'(k * 37 + mode * 1000 + 5), k, mode, k[0]);
        if (k == 2) begin
          // R7 and R8: line stays valid while idle, stray beats ignored
          stray_en = 1;
          repeat (2) step();
          stray_en = 0;
        end
      end
    // back-to-back wrap refills at the top offset, then linear with high offset
    run_refill(LINE_W'(27'h3ff_ffff), 7, 0, 1);
    run_refill(LINE_W'(27'h155_5555), 6, 1, 0);
    repeat (2) step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule